// File: doc/BRIEF.md
# Stereo Sample Router and Attenuator

This block takes one 32-bit word per sample holding two signed 16-bit channel values and produces a left and a right 16-bit output sample. A configuration register decides how the two halves of the word map to the outputs. The halves can pass straight through, pass with left and right exchanged, or be folded into a single mono value that drives both outputs. Each output then gets its own attenuation in 1 dB steps, or is silenced.

Samples enter and leave on valid/ready handshakes through a two-stage registered pipeline. Downstream backpressure propagates upstream. The configuration register is written over a plain write strobe and data bus and can always be read back. A write-protect input blocks updates while it is high. Settings are captured together with each sample when that sample is accepted, so a write never changes a sample that is already in flight.

Top module: `stereo_router_atten`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00004E4E (both attenuation codes 78, swap, mono and mono mode 0), `out_valid` is 0 and `in_ready` is 1.
- R2: A cycle with `cfg_wr_en`=1 and `wp_en`=0 loads the register. From the next cycle `cfg_rdata` equals the written word masked to 0x000F7F7F. The fields are left attenuation [6:0], right attenuation [14:8], swap [16], mono enable [17] and mono mode [19:18].
- R3: A cycle with `cfg_wr_en`=1 and `wp_en`=1 leaves `cfg_rdata` and all behaviour unchanged.
- R4: With mono disabled and swap 0, the left output takes `in_data[15:0]` and the right output takes `in_data[31:16]`. With swap 1, the two halves are exchanged.
- R5: With mono enabled in mode 0, both outputs take floor((left+right)/2), computed on a 17-bit sum.
- R6: With mono enabled in mode 1, both outputs take left+right clamped to the range -32768..32767.
- R7: With mono enabled, mode 2 drives both outputs with `in_data[15:0]` and mode 3 drives both with `in_data[31:16]`, whatever the swap setting.
- R8: An attenuation code N from 0 to 77 scales the sample by gain G(N). The gain is built from A0 = 2^30 and A(k+1) = (A(k)*956973408 + 2^29) >> 30, with G(N) = (A(N) + 2^14) >> 15. The output is (x*G + 2^14) >>> 15, truncated to 16 bits. Code 0 returns the sample unchanged.
- R9: An attenuation code from 78 to 127 drives that channel's output to 0.
- R10: An accepted sample appears on the outputs two cycles later when the path is free. While `out_valid`=1 and `out_ready`=0, the outputs hold. A full pipeline drops `in_ready`. No sample is lost or duplicated.
- R11: A sample accepted in the same cycle as a register write uses the settings from before the write. Samples accepted later use the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| wp_en | input | 1 | Write protect; writes are ignored while high |
| cfg_rdata | output | 32 | Current register contents |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 32 | Stereo sample word, two signed 16-bit halves |
| out_valid | output | 1 | Output sample pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_left | output | 16 | Left output sample, signed |
| out_right | output | 16 | Right output sample, signed |

## Verification
The interesting collision is a register write and a sample acceptance at the same clock edge. The sample must keep the old settings, and the write must still land for the next sample. The bench forces this with one directed pair of samples around a swap write. Random traffic also overlaps writes, with and without protection, with accepts and with downstream stalls. A behavioural queue model updates its own copy of the register only after it has queued the sample taken on that edge. Every output pair is compared against that model, and each compare is tagged with the same-cycle rule when a write coincided.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;
  localparam int SMP_W     = 16;
  localparam int WORD_W    = 2 * SMP_W;
  localparam int CSR_W     = 32;
  localparam int ATT_W     = 7;
  localparam int ATT_STEPS = 78;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int ACC_FRAC  = 30;
  localparam int PROD_W    = SMP_W + GAIN_W + 1;
  localparam logic [63:0] STEP_K = 64'd956973408;  // -1 dB step, Q2.30
  localparam logic [ATT_W-1:0] ATT_RESET = ATT_W'(ATT_STEPS);
  localparam logic [CSR_W-1:0] CSR_MASK = 32'h000F_7F7F;

  typedef enum logic [1:0] {
    MIX_AVG  = 2'd0,
    MIX_SAT  = 2'd1,
    MIX_LOW  = 2'd2,
    MIX_HIGH = 2'd3
  } mono_mode_e;

  typedef struct packed {
    mono_mode_e       mode;
    logic             mono;
    logic             swap;
    logic [ATT_W-1:0] att_r;
    logic [ATT_W-1:0] att_l;
  } cfg_t;

  typedef logic [ATT_STEPS-1:0][GAIN_W-1:0] gain_tab_t;

  // Gain table: repeated multiplication by the 1 dB factor in Q2.30
  function automatic gain_tab_t build_gains();
    logic [63:0] acc;
    gain_tab_t   tab;
    acc = 64'd1 << ACC_FRAC;
    for (int n = 0; n < ATT_STEPS; n++) begin
      tab[n] = GAIN_W'((acc + (64'd1 << (GAIN_FRAC - 1))) >> GAIN_FRAC);
      acc    = (acc * STEP_K + (64'd1 << (ACC_FRAC - 1))) >> ACC_FRAC;
    end
    return tab;
  endfunction

  // Returns {right, left} after swap / mono folding
  function automatic logic [WORD_W-1:0] route(logic [WORD_W-1:0] w, cfg_t c);
    logic [SMP_W-1:0] lo, hi, l, r, mix;
    logic [SMP_W:0]   sum;
    lo  = w[SMP_W-1:0];
    hi  = w[WORD_W-1:SMP_W];
    l   = c.swap ? hi : lo;
    r   = c.swap ? lo : hi;
    sum = {l[SMP_W-1], l} + {r[SMP_W-1], r};
    case (c.mode)
      MIX_AVG: mix = sum[SMP_W:1];
      MIX_SAT: mix = (sum[SMP_W] != sum[SMP_W-1]) ?
                     {sum[SMP_W], {(SMP_W-1){~sum[SMP_W]}}} : sum[SMP_W-1:0];
      MIX_LOW: mix = lo;
      default: mix = hi;
    endcase
    return c.mono ? {mix, mix} : {r, l};
  endfunction

  // Signed sample times unsigned Q1.15 gain, rounded, or zero when muted
  function automatic logic [SMP_W-1:0] attenuate(logic [SMP_W-1:0] x,
                                                 logic [ATT_W-1:0] code,
                                                 gain_tab_t tab);
    logic [GAIN_W-1:0]        g;
    logic signed [PROD_W-1:0] p;
    if (int'(code) >= ATT_STEPS) return '0;
    g = tab[code];
    p = $signed({{(PROD_W-SMP_W){x[SMP_W-1]}}, x}) *
        $signed({{(PROD_W-GAIN_W){1'b0}}, g});
    p = p + $signed(PROD_W'(1) << (GAIN_FRAC - 1));
    return p[SMP_W+GAIN_FRAC-1:GAIN_FRAC];
  endfunction
endpackage

// File: rtl/sra_cfg_reg.sv
`timescale 1ns/1ps
module sra_cfg_reg
  import sra_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wp_en,
  input  logic [CSR_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic [CSR_W-1:0] rdata
);
  logic wr_take;
  logic wr_spare_unused;
  cfg_t wr_cfg;

  assign wr_take         = wr_en & ~wp_en;
  assign wr_spare_unused = ^{wr_data[CSR_W-1:20], wr_data[15], wr_data[7]};

  always_comb begin
    wr_cfg.att_l = wr_data[ATT_W-1:0];
    wr_cfg.att_r = wr_data[8 +: ATT_W];
    wr_cfg.swap  = wr_data[16];
    wr_cfg.mono  = wr_data[17];
    wr_cfg.mode  = mono_mode_e'(wr_data[19:18]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '{mode: MIX_AVG, mono: 1'b0, swap: 1'b0,
               att_r: ATT_RESET, att_l: ATT_RESET};
    end else if (wr_take) begin
      cfg <= wr_cfg;
    end
  end

  assign rdata = {12'b0, cfg.mode, cfg.mono, cfg.swap,
                  1'b0, cfg.att_r, 1'b0, cfg.att_l};
endmodule

// File: rtl/sra_route_stage.sv
`timescale 1ns/1ps
module sra_route_stage
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  cfg_t              cfg,
  input  logic              dn_ready,
  output logic              in_ready,
  output logic              s_valid,
  output logic [SMP_W-1:0]  s_left,
  output logic [SMP_W-1:0]  s_right,
  output logic [ATT_W-1:0]  s_att_l,
  output logic [ATT_W-1:0]  s_att_r
);
  logic [WORD_W-1:0] routed;

  assign in_ready = ~s_valid | dn_ready;
  assign routed   = route(in_data, cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_left  <= '0;
      s_right <= '0;
      s_att_l <= '0;
      s_att_r <= '0;
    end else if (in_ready) begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_left  <= routed[SMP_W-1:0];
        s_right <= routed[WORD_W-1:SMP_W];
        s_att_l <= cfg.att_l;
        s_att_r <= cfg.att_r;
      end
    end
  end
endmodule

// File: rtl/sra_atten_stage.sv
`timescale 1ns/1ps
module sra_atten_stage
  import sra_pkg::*;
#(
  parameter int N_CH = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  input  logic [SMP_W-1:0] up_left,
  input  logic [SMP_W-1:0] up_right,
  input  logic [ATT_W-1:0] up_att_l,
  input  logic [ATT_W-1:0] up_att_r,
  input  logic             out_ready,
  output logic             up_ready,
  output logic             out_valid,
  output logic [SMP_W-1:0] out_left,
  output logic [SMP_W-1:0] out_right
);
  localparam gain_tab_t GAINS = build_gains();

  logic [N_CH-1:0][SMP_W-1:0] smp_in, scaled, held;
  logic [N_CH-1:0][ATT_W-1:0] att_in;

  assign smp_in   = {up_right, up_left};
  assign att_in   = {up_att_r, up_att_l};
  assign up_ready = ~out_valid | out_ready;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    assign scaled[ch] = attenuate(smp_in[ch], att_in[ch], GAINS);
    always_ff @(posedge clk) begin
      if (!rst_n) held[ch] <= '0;
      else if (up_ready && up_valid) held[ch] <= scaled[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (up_ready) out_valid <= up_valid;
  end

  assign out_left  = held[0];
  assign out_right = held[1];
endmodule

// File: rtl/stereo_router_atten.sv
`timescale 1ns/1ps
module stereo_router_atten
  import sra_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  input  logic        wp_en,
  output logic [31:0] cfg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_left,
  output logic [15:0] out_right
);
  cfg_t             cfg;
  logic             s1_valid;
  logic [SMP_W-1:0] s1_left, s1_right;
  logic [ATT_W-1:0] s1_att_l, s1_att_r;
  logic             s2_ready;

  sra_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wp_en(wp_en),
    .wr_data(cfg_wr_data), .cfg(cfg), .rdata(cfg_rdata)
  );

  sra_route_stage u_route (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg(cfg), .dn_ready(s2_ready), .in_ready(in_ready),
    .s_valid(s1_valid), .s_left(s1_left), .s_right(s1_right),
    .s_att_l(s1_att_l), .s_att_r(s1_att_r)
  );

  sra_atten_stage #(.N_CH(2)) u_atten (
    .clk(clk), .rst_n(rst_n), .up_valid(s1_valid),
    .up_left(s1_left), .up_right(s1_right),
    .up_att_l(s1_att_l), .up_att_r(s1_att_r),
    .out_ready(out_ready), .up_ready(s2_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );
endmodule

// File: rtl/sra_checker.sv
`timescale 1ns/1ps
module sra_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic        wp_en,
  input logic [31:0] cfg_wr_data,
  input logic [31:0] cfg_rdata,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_left,
  input logic [15:0] out_right,
  input logic        s1_valid,
  input logic [6:0]  s1_att_l,
  input logic [6:0]  s1_att_r,
  input logic        s2_ready
);
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && !wp_en |=> cfg_rdata == ($past(cfg_wr_data) & 32'h000F_7F7F)); // R2
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && wp_en |=> $stable(cfg_rdata)); // R3
  AST_MUTE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s2_ready && s1_att_l > 7'd77 |=> out_left == 16'h0); // R9
  AST_MUTE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s2_ready && s1_att_r > 7'd77 |=> out_right == 16'h0); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right)); // R10
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready); // R10
endmodule

bind stereo_router_atten sra_checker u_sra_checker (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .wp_en(wp_en),
  .cfg_wr_data(cfg_wr_data), .cfg_rdata(cfg_rdata), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
  .out_right(out_right), .s1_valid(s1_valid), .s1_att_l(s1_att_l),
  .s1_att_r(s1_att_r), .s2_ready(s2_ready)
);

// File: tb/test_stereo_router_atten.sv
`timescale 1ns/1ps
module test_stereo_router_atten;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, wp_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] cfg_wr_data = '0, in_data = '0;
  logic [31:0] cfg_rdata;
  logic        in_ready, out_valid;
  logic [15:0] out_left, out_right;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  logic [15:0] q_l[$], q_r[$];
  string       q_tl[$], q_tr[$];
  logic [31:0] m_cfg = 32'h0000_4E4E;
  string       cfg_tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  stereo_router_atten i_stereo_router_atten (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .wp_en(wp_en), .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint gain_ref(int n);
    longint a = 64'sd1073741824;
    for (int i = 0; i < n; i++) a = (a * 64'sd956973408 + 64'sd536870912) >>> 30;
    return (a + 16384) >>> 15;
  endfunction

  function automatic logic [15:0] att_ref(int x, int code);
    longint p;
    if (code > 77) return 16'h0;
    p = longint'(x) * gain_ref(code);
    p = (p + 16384) >>> 15;
    return p[15:0];
  endfunction

  function automatic int sx(logic [15:0] v);
    return int'($signed(v));
  endfunction

  // Push expected output pair for word w under register value c
  task automatic push_expect(logic [31:0] w, logic [31:0] c, bit same_cycle_wr);
    int lo, hi, l, r, s, m, al, ar;
    string base;
    lo = sx(w[15:0]); hi = sx(w[31:16]);
    l = c[16] ? hi : lo;
    r = c[16] ? lo : hi;
    al = int'(c[6:0]); ar = int'(c[14:8]);
    base = "R4";
    if (c[17]) begin
      s = l + r;
      case (c[19:18])
        2'd0: begin m = (s - (s & 1)) / 2; base = "R5"; end
        2'd1: begin m = (s > 32767) ? 32767 : (s < -32768) ? -32768 : s; base = "R6"; end
        2'd2: begin m = lo; base = "R7"; end
        default: begin m = hi; base = "R7"; end
      endcase
      l = m; r = m;
    end
    if (same_cycle_wr) base = {"R11 ", base};
    q_l.push_back(att_ref(l, al));
    q_r.push_back(att_ref(r, ar));
    q_tl.push_back({base, (al > 77) ? " R9 left" : " R8 left"});
    q_tr.push_back({base, (ar > 77) ? " R9 right" : " R8 right"});
  endtask

  // Reference model, evaluated 1 ns after each falling edge
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      chk(cfg_rdata == m_cfg, cfg_tag, cfg_rdata, m_cfg);
      if (in_valid && in_ready) push_expect(in_data, m_cfg, cfg_wr_en && !wp_en);
      if (out_valid && out_ready) begin
        if (q_l.size() == 0) chk(1'b0, "R10 unexpected output", {out_right, out_left}, 32'h0);
        else begin
          logic [15:0] el, er;
          string tl, tr;
          el = q_l.pop_front(); er = q_r.pop_front();
          tl = q_tl.pop_front(); tr = q_tr.pop_front();
          chk(out_left == el, tl, {16'h0, out_left}, {16'h0, el});
          chk(out_right == er, tr, {16'h0, out_right}, {16'h0, er});
        end
      end
      if (cfg_wr_en) begin
        if (!wp_en) begin m_cfg = cfg_wr_data & 32'h000F_7F7F; cfg_tag = "R2"; end
        else cfg_tag = "R3";
      end
    end
  end

  task automatic wr_cfg(logic [31:0] d, bit prot);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d; wp_en = prot;
    @(negedge clk);
    cfg_wr_en = 1'b0; wp_en = 1'b0;
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    int att_list[8] = '{0, 1, 6, 20, 77, 78, 100, 127};
    logic [15:0] hold_l, hold_r;
    repeat (5) @(negedge clk);
    chk(cfg_rdata == 32'h0000_4E4E, "R1 reset register", cfg_rdata, 32'h0000_4E4E);
    chk(out_valid == 1'b0, "R1 reset out_valid", {31'b0, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R1 reset in_ready", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;

    // R10 latency
    wr_cfg(32'h0, 1'b0);
    @(negedge clk); in_valid = 1'b1; in_data = 32'h1234_5678; out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10 one cycle after accept", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    chk(out_valid && out_left == 16'h5678 && out_right == 16'h1234, "R10 two cycles",
        {out_right, out_left}, 32'h1234_5678);

    // R11 write and accept on the same edge
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = 32'h0001_0000;
    in_valid = 1'b1; in_data = 32'hAAAA_1111;
    @(negedge clk); cfg_wr_en = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    chk(out_left == 16'h1111, "R11 old settings kept", {16'h0, out_left}, 32'h1111);
    @(negedge clk);
    chk(out_left == 16'hAAAA, "R11 new settings used", {16'h0, out_left}, 32'hAAAA);

    // R10 backpressure
    wr_cfg(32'h0, 1'b0);
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_data = 32'h0002_0001;
    @(negedge clk); in_data = 32'h0004_0003;
    @(negedge clk); in_data = 32'h0006_0005;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 full pipe stalls input", {31'b0, in_ready}, 32'h0);
    hold_l = out_left; hold_r = out_right;
    repeat (3) @(negedge clk);
    chk(out_valid && out_left == hold_l && out_right == hold_r, "R10 output held",
        {out_right, out_left}, {hold_r, hold_l});
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);

    // Mode sweep
    for (int i = 0; i < 16; i++) begin
      logic [31:0] c;
      c = {12'b0, 2'(i / 4), 1'(i % 2), 1'((i / 2) % 2), 1'b0,
           7'(att_list[(i + 3) % 8]), 1'b0, 7'(att_list[i % 8])};
      wr_cfg(c, 1'b0);
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        in_valid = ($urandom % 4) != 0;
        out_ready = ($urandom % 3) != 0;
        in_data = {pick16(), pick16()};
      end
    end

    // Writes with and without protection during traffic
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      cfg_wr_en = ($urandom % 6) == 0;
      wp_en = ($urandom % 2) != 0;
      cfg_wr_data = $urandom;
      in_valid = ($urandom % 3) != 0;
      out_ready = ($urandom % 4) != 0;
      in_data = {pick16(), pick16()};
    end
    @(negedge clk); cfg_wr_en = 1'b0; wp_en = 1'b0;
    wr_cfg(32'h0000_0000, 1'b1);  // R3 directed blocked write
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    repeat (8) @(negedge clk);
    #1;
    chk(q_l.size() == 0, "R10 all samples delivered", q_l.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule